// File: doc/BRIEF.md
# Strided Word Copy Engine

This block moves a run of 32-bit words from one place in a memory-mapped system to another. A supervising processor programs five values into a small register bank: where to read, where to write, how far to step the read address after each word, how far to step the write address after each word, and how many words to move. A single start command then hands the job to a control state machine. That machine acts as the only master on a Wishbone port. It reads one word from the source and writes the same word to the destination, then repeats.

The two steps are independent, signed and may be zero. One instruction can therefore empty a fixed-address FIFO data port into a linear RAM region, fill such a port from a RAM region, walk a buffer backwards, or gather words at a fixed stride. Completion and bus errors are reported through sticky status flags. The processor polls these flags and clears them by writing ones.

Top module: `wb_stride_mover`

## Requirements
- R1: The register bank has these word indices on `cfg_addr`: 0 holds the source address, 1 the destination address, 2 the steps (source step in bits 15:0, destination step in bits 31:16), 3 the word count, 4 control on write and status on read, and 5 the count of words moved (read only). The fields in 0 to 3 read back what was written. `cfg_rdata` shows the register selected by `cfg_addr` one clock after that address is presented.
- R2: Writing 1 to control bit 0 while the engine is idle latches all five fields into the engine. It also sets BUSY (status bit 0) and clears DONE and ERROR. Field writes made after that do not change the move in progress.
- R3: A start written while BUSY is set is ignored: the running move keeps its original fields and its word count.
- R4: Each word is one Wishbone read at the source address followed by one write of the captured data to the destination address. Writes use SEL all ones. STB is only ever high together with CYC, and at most one cycle is outstanding. Address, WE and write data stay stable until ACK or ERR.
- R5: After every completed word, the source and destination addresses each advance by their own step, sign-extended from 16 bits. A step of 0 keeps that address fixed, and a negative step moves it downwards.
- R6: After N words, BUSY clears, DONE (status bit 1) sets, and the moved count equals N. DONE stays set until software writes 1 to control bit 1. Writing 0 there leaves DONE set.
- R7: A start with a word count of 0 ends at once: DONE is set on the next cycle and no bus cycle is issued.
- R8: An ERR response on either the read or the write drops CYC, clears BUSY and sets ERROR (status bit 2) without setting DONE. The moved count then holds the number of words completed before the error. Writing 1 to control bit 2 clears ERROR.
- R9: After a synchronous reset, all fields, flags and the moved count are zero, and CYC and STB are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for writes and reads |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Registered read data of the indexed register |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | AW | Wishbone address |
| wb_sel_o | output | DW/8 | Wishbone byte selects |
| wb_dat_o | output | DW | Wishbone write data |
| wb_dat_i | input | DW | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error response |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses and data, a 16-bit word count and 16-bit steps. At these sizes, negative steps and address wrap-around can be driven directly. The memory model decodes only the low eight address bits, so random strides of -4 to +4 wrap across a 256-word space and overlapping source and destination runs come up naturally. The model inserts random wait states and can answer one chosen write address with ERR. This reaches aborts in the middle of a move, late-arriving ACKs and the full set of zero-step FIFO patterns.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  localparam logic [2:0] REG_SRC   = 3'd0;
  localparam logic [2:0] REG_DST   = 3'd1;
  localparam logic [2:0] REG_STEP  = 3'd2;
  localparam logic [2:0] REG_CNT   = 3'd3;
  localparam logic [2:0] REG_CTRL  = 3'd4;
  localparam logic [2:0] REG_MOVED = 3'd5;

  localparam int CTRL_START   = 0;
  localparam int CTRL_DONE_CL = 1;
  localparam int CTRL_ERR_CL  = 2;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SETUP = 2'd1,
    ENG_READ  = 2'd2,
    ENG_WRITE = 2'd3
  } eng_state_t;

endpackage

// File: rtl/wbm_stride_addr.sv
module wbm_stride_addr #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] step,
  input  logic          advance,
  output logic [AW-1:0] addr
);

  localparam int EXT = AW - SW;

  logic [SW-1:0] step_q;
  logic [AW-1:0] step_ext;

  assign step_ext = {{EXT{step_q[SW-1]}}, step_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      step_q <= '0;
    end else if (load) begin
      addr   <= base;
      step_q <= step;
    end else if (advance) begin
      addr   <= addr + step_ext;
    end
  end

endmodule

// File: rtl/wbm_regbank.sv
module wbm_regbank
  import wbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          fin_ok,
  input  logic          fin_err,
  input  logic [CW-1:0] moved,
  output logic          start,
  output logic [AW-1:0] src_base,
  output logic [AW-1:0] dst_base,
  output logic [SW-1:0] src_step,
  output logic [SW-1:0] dst_step,
  output logic [CW-1:0] count,
  output logic          busy
);

  localparam int STEPS_W = 2 * SW;

  logic          done_q;
  logic          error_q;
  logic          ctrl_wr;
  logic [DW-1:0] rd_next;

  assign ctrl_wr = cfg_we && (cfg_addr == REG_CTRL);
  assign start   = ctrl_wr && cfg_wdata[CTRL_START] && !busy;

  always_comb begin
    case (cfg_addr)
      REG_SRC:   rd_next = DW'(src_base);
      REG_DST:   rd_next = DW'(dst_base);
      REG_STEP:  rd_next = DW'({dst_step, src_step});
      REG_CNT:   rd_next = DW'(count);
      REG_CTRL:  rd_next = DW'({error_q, done_q, busy});
      REG_MOVED: rd_next = DW'(moved);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base  <= '0;
      dst_base  <= '0;
      src_step  <= '0;
      dst_step  <= '0;
      count     <= '0;
      busy      <= 1'b0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          REG_SRC:  src_base <= cfg_wdata[AW-1:0];
          REG_DST:  dst_base <= cfg_wdata[AW-1:0];
          REG_STEP: begin
            src_step <= cfg_wdata[SW-1:0];
            dst_step <= cfg_wdata[STEPS_W-1:SW];
          end
          REG_CNT:  count <= cfg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (start) begin
        busy    <= 1'b1;
        done_q  <= 1'b0;
        error_q <= 1'b0;
      end else begin
        if (fin_ok) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (ctrl_wr && cfg_wdata[CTRL_DONE_CL]) begin
          done_q <= 1'b0;
        end
        if (fin_err) begin
          busy    <= 1'b0;
          error_q <= 1'b1;
        end else if (ctrl_wr && cfg_wdata[CTRL_ERR_CL]) begin
          error_q <= 1'b0;
        end
      end
      cfg_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/wbm_engine.sv
module wbm_engine
  import wbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW-1:0]   count_in,
  input  logic [AW-1:0]   src_addr,
  input  logic [AW-1:0]   dst_addr,
  output logic            advance,
  output logic            wb_cyc_o,
  output logic            wb_stb_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_adr_o,
  output logic [DW/8-1:0] wb_sel_o,
  output logic [DW-1:0]   wb_dat_o,
  input  logic [DW-1:0]   wb_dat_i,
  input  logic            wb_ack_i,
  input  logic            wb_err_i,
  output logic            fin_ok,
  output logic            fin_err,
  output logic [CW-1:0]   moved,
  output logic [CW-1:0]   cnt_lat
);

  localparam logic [CW-1:0] ONE = CW'(1);

  eng_state_t    state_q;
  logic          on_bus;
  logic [CW-1:0] moved_inc;

  assign on_bus    = (state_q == ENG_READ) || (state_q == ENG_WRITE);
  assign moved_inc = moved + ONE;
  assign advance   = (state_q == ENG_WRITE) && wb_ack_i && !wb_err_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENG_IDLE;
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_sel_o <= '0;
      wb_dat_o <= '0;
      fin_ok   <= 1'b0;
      fin_err  <= 1'b0;
      moved    <= '0;
      cnt_lat  <= '0;
    end else begin
      fin_ok  <= 1'b0;
      fin_err <= 1'b0;
      if (on_bus && wb_err_i) begin
        wb_cyc_o <= 1'b0;
        wb_stb_o <= 1'b0;
        wb_we_o  <= 1'b0;
        wb_sel_o <= '0;
        fin_err  <= 1'b1;
        state_q  <= ENG_IDLE;
      end else begin
        case (state_q)
          ENG_IDLE: begin
            if (start) begin
              cnt_lat <= count_in;
              moved   <= '0;
              if (count_in == '0) fin_ok <= 1'b1;
              else                state_q <= ENG_SETUP;
            end
          end
          ENG_SETUP: begin
            wb_cyc_o <= 1'b1;
            wb_stb_o <= 1'b1;
            wb_we_o  <= 1'b0;
            wb_sel_o <= '1;
            wb_adr_o <= src_addr;
            state_q  <= ENG_READ;
          end
          ENG_READ: begin
            if (wb_ack_i) begin
              wb_we_o  <= 1'b1;
              wb_adr_o <= dst_addr;
              wb_dat_o <= wb_dat_i;
              state_q  <= ENG_WRITE;
            end
          end
          ENG_WRITE: begin
            if (wb_ack_i) begin
              wb_cyc_o <= 1'b0;
              wb_stb_o <= 1'b0;
              wb_we_o  <= 1'b0;
              wb_sel_o <= '0;
              moved    <= moved_inc;
              if (moved_inc == cnt_lat) begin
                fin_ok  <= 1'b1;
                state_q <= ENG_IDLE;
              end else begin
                state_q <= ENG_SETUP;
              end
            end
          end
          default: state_q <= ENG_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/wb_stride_mover.sv
module wb_stride_mover
  import wbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            wb_cyc_o,
  output logic            wb_stb_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_adr_o,
  output logic [DW/8-1:0] wb_sel_o,
  output logic [DW-1:0]   wb_dat_o,
  input  logic [DW-1:0]   wb_dat_i,
  input  logic            wb_ack_i,
  input  logic            wb_err_i
);

  localparam int SIDES = 2;

  logic          start;
  logic          busy;
  logic          fin_ok;
  logic          fin_err;
  logic          advance;
  logic [CW-1:0] moved;
  logic [CW-1:0] count;
  logic [CW-1:0] cnt_lat;
  logic [AW-1:0] src_base, dst_base;
  logic [SW-1:0] src_step, dst_step;

  logic [AW-1:0] base_a [SIDES];
  logic [SW-1:0] step_a [SIDES];
  logic [AW-1:0] addr_a [SIDES];

  assign base_a[0] = src_base;
  assign base_a[1] = dst_base;
  assign step_a[0] = src_step;
  assign step_a[1] = dst_step;

  wbm_regbank #(.AW(AW), .DW(DW), .CW(CW), .SW(SW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .moved     (moved),
    .start     (start),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .count     (count),
    .busy      (busy)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    wbm_stride_addr #(.AW(AW), .SW(SW)) u_addr (
      .clk     (clk),
      .rst     (rst),
      .load    (start),
      .base    (base_a[g]),
      .step    (step_a[g]),
      .advance (advance),
      .addr    (addr_a[g])
    );
  end

  wbm_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .count_in (count),
    .src_addr (addr_a[0]),
    .dst_addr (addr_a[1]),
    .advance  (advance),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_adr_o (wb_adr_o),
    .wb_sel_o (wb_sel_o),
    .wb_dat_o (wb_dat_o),
    .wb_dat_i (wb_dat_i),
    .wb_ack_i (wb_ack_i),
    .wb_err_i (wb_err_i),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .moved    (moved),
    .cnt_lat  (cnt_lat)
  );

endmodule

// File: rtl/wb_stride_mover_chk.sv
module wb_stride_mover_chk
  import wbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [2:0]      cfg_addr,
  input logic [DW-1:0]   cfg_wdata,
  input logic            wb_cyc_o,
  input logic            wb_stb_o,
  input logic            wb_we_o,
  input logic [AW-1:0]   wb_adr_o,
  input logic [DW/8-1:0] wb_sel_o,
  input logic [DW-1:0]   wb_dat_o,
  input logic            wb_ack_i,
  input logic            wb_err_i,
  input logic            busy,
  input logic            start,
  input logic [CW-1:0]   count,
  input logic            fin_ok,
  input logic            fin_err,
  input logic [CW-1:0]   moved,
  input logic [CW-1:0]   cnt_lat
);

  assert_stb_in_cyc_R4: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  assert_sel_full_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_we_o) |-> (wb_sel_o == '1));

  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_stb_o && !wb_ack_i && !wb_err_i) |=>
      (wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

  assert_cyc_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o |-> busy);

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_we && cfg_addr == REG_CTRL && cfg_wdata[CTRL_START]) |=> $stable(cnt_lat));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
    (start && count == '0) |=> (!wb_cyc_o && fin_ok));

  assert_err_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_err_i) |=> (!wb_cyc_o && fin_err));

  assert_moved_bound_R6: assert property (@(posedge clk) disable iff (rst)
    moved <= cnt_lat);

endmodule

bind wb_stride_mover wb_stride_mover_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .wb_cyc_o  (wb_cyc_o),
  .wb_stb_o  (wb_stb_o),
  .wb_we_o   (wb_we_o),
  .wb_adr_o  (wb_adr_o),
  .wb_sel_o  (wb_sel_o),
  .wb_dat_o  (wb_dat_o),
  .wb_ack_i  (wb_ack_i),
  .wb_err_i  (wb_err_i),
  .busy      (busy),
  .start     (start),
  .count     (count),
  .fin_ok    (fin_ok),
  .fin_err   (fin_err),
  .moved     (moved),
  .cnt_lat   (cnt_lat)
);

// File: tb/test_wb_stride_mover.sv
module test_wb_stride_mover;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [31:0] wb_adr_o, wb_dat_o;
  logic [3:0]  wb_sel_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack_i = 1'b0;
  logic        wb_err_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int sel_bad = 0;
  int wait_cnt = 0;
  logic       err_en = 1'b0;
  logic [7:0] err_addr = '0;
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];

  always #5 clk = ~clk;

  wb_stride_mover i_wb_stride_mover (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i)
  );

  // memory model with random wait states and optional error on one write address
  always @(posedge clk) begin
    if (rst) begin
      wb_ack_i <= 1'b0;
      wb_err_i <= 1'b0;
      wait_cnt <= 0;
    end else if (wb_ack_i || wb_err_i) begin
      wb_ack_i <= 1'b0;
      wb_err_i <= 1'b0;
      wait_cnt <= int'($urandom_range(2));
    end else if (wb_cyc_o && wb_stb_o) begin
      if (wait_cnt != 0) wait_cnt <= wait_cnt - 1;
      else if (err_en && wb_we_o && wb_adr_o[7:0] == err_addr) wb_err_i <= 1'b1;
      else begin
        wb_ack_i <= 1'b1;
        if (wb_we_o) begin
          mem[wb_adr_o[7:0]] <= wb_dat_o;
          wr_cnt <= wr_cnt + 1;
          if (wb_sel_o != 4'hF) sel_bad <= sel_bad + 1;
        end else begin
          wb_dat_i <= mem[wb_adr_o[7:0]];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int n = 0;
    st = 32'h1;
    while (st[0] && n < 5000) begin
      cfg_read(3'd4, st);
      n++;
    end
  endtask

  function automatic void model_move(int s, int d, int ss, int ds, int n);
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    for (int i = 0; i < n; i++) begin
      ref_mem[d & 255] = ref_mem[s & 255];
      s = s + ss;
      d = d + ds;
    end
  endfunction

  function automatic int mem_mismatch();
    int m = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) m++;
    return m;
  endfunction

  task automatic program_move(input int s, input int d, input int ss, input int ds, input int n);
    cfg_write(3'd0, 32'(s));
    cfg_write(3'd1, 32'(d));
    cfg_write(3'd2, {16'(ds), 16'(ss)});
    cfg_write(3'd3, 32'(n));
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; sel_bad = 0;
    cfg_write(3'd4, 32'h1);
  endtask

  task automatic run_move(input string tag, input int s, input int d,
                          input int ss, input int ds, input int n);
    logic [31:0] v;
    model_move(s, d, ss, ds, n);
    program_move(s, d, ss, ds, n);
    wait_idle();
    chk({tag, " R4 R5 memory image"}, 32'(mem_mismatch()), 32'd0);
    chk({tag, " R4 read cycles"}, 32'(rd_cnt), 32'(n));
    chk({tag, " R4 write cycles"}, 32'(wr_cnt), 32'(n));
    chk({tag, " R4 sel all ones"}, 32'(sel_bad), 32'd0);
    cfg_read(3'd4, v);
    chk({tag, " R6 status done"}, v, 32'h2);
    cfg_read(3'd5, v);
    chk({tag, " R6 moved count"}, v, 32'(n));
    cfg_write(3'd4, 32'h2);
  endtask

  initial begin
    logic [31:0] v;
    int sd;
    sd = int'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    cfg_read(3'd4, v);  chk("R9 status after reset", v, 32'h0);
    cfg_read(3'd0, v);  chk("R9 source field after reset", v, 32'h0);
    cfg_read(3'd5, v);  chk("R9 moved after reset", v, 32'h0);
    chk("R9 bus idle after reset", {30'd0, wb_cyc_o, wb_stb_o}, 32'h0);

    // R1 readback
    cfg_write(3'd0, 32'h1234_5678); cfg_read(3'd0, v); chk("R1 source readback", v, 32'h1234_5678);
    cfg_write(3'd1, 32'hCAFE_0010); cfg_read(3'd1, v); chk("R1 dest readback", v, 32'hCAFE_0010);
    cfg_write(3'd2, 32'hFFFE_0003); cfg_read(3'd2, v); chk("R1 steps readback", v, 32'hFFFE_0003);
    cfg_write(3'd3, 32'h0000_BEEF); cfg_read(3'd3, v); chk("R1 count readback", v, 32'h0000_BEEF);

    // R7 zero count
    program_move(16, 32, 1, 1, 0);
    @(negedge clk);
    cfg_read(3'd4, v);
    chk("R7 zero count done", v, 32'h2);
    chk("R7 zero count no bus cycles", 32'(rd_cnt + wr_cnt), 32'd0);

    // R6 done sticky: writing 0 keeps it, writing 1 clears
    cfg_write(3'd4, 32'h0); cfg_read(3'd4, v); chk("R6 done stays on zero write", v, 32'h2);
    cfg_write(3'd4, 32'h2); cfg_read(3'd4, v); chk("R6 done cleared by one", v, 32'h0);

    // R5 FIFO patterns and negative step
    run_move("fifo drain R5", 32'h30, 32'hC0, 0, 1, 5);
    run_move("fifo fill R5", 32'h50, 32'h40, 1, 0, 6);
    run_move("reverse R5", 32'h70, 32'hE0, -1, 2, 7);

    // R2 R3 start while busy is ignored, field writes do not disturb
    model_move(32'h20, 32'hA0, 1, 1, 10);
    program_move(32'h20, 32'hA0, 1, 1, 10);
    cfg_read(3'd4, v);
    chk("R2 busy after start", v, 32'h1);
    cfg_write(3'd3, 32'd3);
    cfg_write(3'd0, 32'h0);
    cfg_write(3'd4, 32'h1);
    wait_idle();
    cfg_read(3'd5, v);  chk("R3 moved keeps original count", v, 32'd10);
    chk("R3 R2 memory of original move", 32'(mem_mismatch()), 32'd0);
    cfg_write(3'd4, 32'h2);

    // R8 error on third write
    model_move(32'h10, 32'h80, 1, 1, 2);
    err_en = 1'b1; err_addr = 8'h82;
    program_move(32'h10, 32'h80, 1, 1, 6);
    wait_idle();
    err_en = 1'b0;
    cfg_read(3'd4, v);  chk("R8 error flag without done", v, 32'h4);
    cfg_read(3'd5, v);  chk("R8 words moved before error", v, 32'd2);
    chk("R8 memory after abort", 32'(mem_mismatch()), 32'd0);
    chk("R8 bus released", {31'd0, wb_cyc_o}, 32'd0);
    cfg_write(3'd4, 32'h4); cfg_read(3'd4, v); chk("R8 error cleared", v, 32'h0);

    // random moves
    for (int t = 0; t < 20; t++) begin
      int s, d, ss, ds, n;
      s  = int'($urandom_range(255));
      d  = int'($urandom_range(255));
      ss = int'($urandom_range(8)) - 4;
      ds = int'($urandom_range(8)) - 4;
      n  = int'($urandom_range(12));
      run_move($sformatf("random %0d", t), s, d, ss, ds, n);
    end

    finish_run();
  end

endmodule